// File: doc/BRIEF.md
# Lower-Order Path V5 Overhead Monitor

This block watches the V5 overhead byte of a lower-order tributary path. The byte arrives once per tributary multiframe. The block decodes three fields from it. The remote error bit produces a one-cycle event pulse, which an external error counter consumes. The remote failure bit is copied straight into a status flag, with no filtering. The three-bit signal label is sorted into one of two classes, acceptable or mismatched. A class must persist before the mismatch status moves, in either direction.

Every status change and every remote error sets a sticky interrupt bit. Software clears an interrupt bit by writing a one to its bit of the clear input. While the mismatch status is set, an AIS-force output tells the tributary data path to replace its outgoing data with an all-ones alarm signal.

V5 bytes enter on a valid/ready stream interface. The block has no back-pressure: `v5_ready` is always high. Every cycle with `v5_valid` high delivers exactly one multiframe's byte. Bytes that arrive on cycles with `v5_valid` low are ignored.

Top module: `v5_mon`

## Requirements
- R1: After reset, `rei_pulse`, `rfi_status`, `slm_status`, `ais_force` and all three `irq` bits are 0.
- R2: `rei_pulse` is high for exactly the one cycle after an accepted byte whose data bit 5 (V5 bit 3, with bits numbered 1..8 from MSB) is 1. It is low on every other cycle.
- R3: From the cycle after an accepted byte, `rfi_status` equals that byte's data bit 4 (V5 bit 4).
- R4: `irq[1]` is set whenever an accepted byte changes `rfi_status`. `irq[0]` is set whenever an accepted byte has its REI bit at 1.
- R5: `slm_status` rises after PERSIST (default 5) consecutive accepted bytes whose label, data bits 3..1, is 3 to 7. The rise is visible in the cycle after the last of those bytes.
- R6: `slm_status` falls after PERSIST consecutive accepted bytes whose label is 0, 1 or 2. The fall is visible in the cycle after the last of those bytes.
- R7: A byte whose label class agrees with the current `slm_status` restarts the persistence run. A mismatched run shorter than PERSIST therefore never changes the status.
- R8: `ais_force` equals `slm_status` on every cycle. Each change of `slm_status` sets `irq[2]`.
- R9: The `irq` bits are sticky. Writing a 1 to bit i of `irq_clr` clears `irq[i]` on the next cycle. A set event in the same cycle takes priority over the clear.
- R10: A cycle with `v5_valid` low changes neither `rfi_status` nor `slm_status`, and it does not advance the persistence run.
- R11: `v5_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v5_byte | input | 8 | Received V5 byte; data bit 7 is V5 bit 1 |
| v5_valid | input | 1 | Marks a byte-carrying cycle, one per multiframe |
| v5_ready | output | 1 | Always 1; the block never stalls |
| irq_clr | input | 3 | Write-one-to-clear for the interrupt bits |
| rei_pulse | output | 1 | One-cycle remote error event to the counter |
| rfi_status | output | 1 | Remote failure indication status |
| slm_status | output | 1 | Persistent signal label mismatch status |
| ais_force | output | 1 | Forces AIS on the outgoing tributary |
| irq | output | 3 | Sticky interrupts: [0] REI, [1] RFI change, [2] mismatch change |

## Verification
The case that is hardest to reach from the ports is a mismatched run that stops one byte short of the persistence threshold. A second hard case is such a run interrupted by idle cycles, which must neither advance nor reset it. The stimulus sends four bad labels, inserts gaps with `v5_valid` low, then sends one good label. It then repeats the run in the clearing direction. Clears that collide with a new event in the same cycle are driven on purpose to check that the set wins.

// File: rtl/v5_mon_pkg.sv
package v5_mon_pkg;
  localparam int unsigned IRQ_W   = 3;
  localparam int unsigned IRQ_REI = 0;
  localparam int unsigned IRQ_RFI = 1;
  localparam int unsigned IRQ_SLM = 2;

  // Field positions within the byte (data bit 7 carries V5 bit 1).
  localparam int unsigned POS_REI = 5;
  localparam int unsigned POS_RFI = 4;
  localparam int unsigned LBL_HI  = 3;
  localparam int unsigned LBL_LO  = 1;
  localparam int unsigned LBL_W   = LBL_HI - LBL_LO + 1;

  // Highest label value this path can process.
  localparam logic [LBL_W-1:0] LBL_MAX_OK = 3'd2;

  typedef struct packed {
    logic             rei;
    logic             rfi;
    logic [LBL_W-1:0] label;
  } v5_fields_t;

  function automatic v5_fields_t split_v5(input logic [7:0] b);
    v5_fields_t f;
    f.rei   = b[POS_REI];
    f.rfi   = b[POS_RFI];
    f.label = b[LBL_HI:LBL_LO];
    return f;
  endfunction
endpackage

// File: rtl/v5_mon_slm_filter.sv
module v5_mon_slm_filter #(
  parameter int unsigned PERSIST = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic bad_label,
  output logic slm_q,
  output logic slm_toggle
);
  localparam int unsigned CW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

  logic [CW-1:0] run_cnt;
  logic          disagree;

  assign disagree   = bad_label != slm_q;
  assign slm_toggle = sample_en && disagree && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      slm_q   <= 1'b0;
    end else if (sample_en) begin
      if (!disagree) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        run_cnt <= '0;
        slm_q   <= ~slm_q;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/v5_mon_irq_bank.sv
module v5_mon_irq_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        irq_q[i] <= 1'b0;
      else if (set_i[i]) irq_q[i] <= 1'b1;
      else if (clr_i[i]) irq_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/v5_mon.sv
module v5_mon
  import v5_mon_pkg::*;
#(
  parameter int unsigned PERSIST = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       v5_byte,
  input  logic             v5_valid,
  output logic             v5_ready,
  input  logic [IRQ_W-1:0] irq_clr,
  output logic             rei_pulse,
  output logic             rfi_status,
  output logic             slm_status,
  output logic             ais_force,
  output logic [IRQ_W-1:0] irq
);
  v5_fields_t       fld;
  logic             accept;
  logic             bad_label;
  logic             slm_toggle;
  logic [IRQ_W-1:0] irq_set;

  assign v5_ready  = 1'b1;
  assign accept    = v5_valid && v5_ready;
  assign fld       = split_v5(v5_byte);
  assign bad_label = fld.label > LBL_MAX_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rei_pulse  <= 1'b0;
      rfi_status <= 1'b0;
    end else begin
      rei_pulse <= accept && fld.rei;
      if (accept) rfi_status <= fld.rfi;
    end
  end

  v5_mon_slm_filter #(.PERSIST(PERSIST)) u_slm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (accept),
    .bad_label  (bad_label),
    .slm_q      (slm_status),
    .slm_toggle (slm_toggle)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_REI] = accept && fld.rei;
    irq_set[IRQ_RFI] = accept && (fld.rfi != rfi_status);
    irq_set[IRQ_SLM] = slm_toggle;
  end

  v5_mon_irq_bank #(.N(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .irq_q (irq)
  );

  assign ais_force = slm_status;
endmodule

// File: rtl/v5_mon_chk.sv
module v5_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] v5_byte,
  input logic       v5_valid,
  input logic [2:0] irq_clr,
  input logic       rei_pulse,
  input logic       rfi_status,
  input logic       slm_status,
  input logic [2:0] irq
);
  AST_REI_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (v5_valid && v5_byte[5]) |=> rei_pulse); // R2
  AST_REI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !v5_valid |=> !rei_pulse); // R2
  AST_RFI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    v5_valid |=> (rfi_status == $past(v5_byte[4]))); // R3
  AST_RFI_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_status != $past(rfi_status)) |-> irq[1]); // R4
  AST_SLM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (slm_status != $past(slm_status)) |-> irq[2]); // R8
  AST_STICKY_REI: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !irq_clr[0]) |=> irq[0]); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !v5_valid |=> ($stable(rfi_status) && $stable(slm_status))); // R10
endmodule

bind v5_mon v5_mon_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .v5_byte    (v5_byte),
  .v5_valid   (v5_valid),
  .irq_clr    (irq_clr),
  .rei_pulse  (rei_pulse),
  .rfi_status (rfi_status),
  .slm_status (slm_status),
  .irq        (irq)
);

// File: tb/v5_mon_tb.sv
module v5_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] v5_byte = 8'h00;
  logic       v5_valid = 1'b0;
  logic [2:0] irq_clr = 3'b000;
  logic       v5_ready, rei_pulse, rfi_status, slm_status, ais_force;
  logic [2:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit       m_rei = 0, m_rfi = 0, m_slm = 0;
  bit [2:0] m_irq = 0;
  int       m_run = 0;

  always #2.5 clk = ~clk;

  v5_mon dut_i (
    .clk(clk), .rst_n(rst_n), .v5_byte(v5_byte), .v5_valid(v5_valid),
    .v5_ready(v5_ready), .irq_clr(irq_clr), .rei_pulse(rei_pulse),
    .rfi_status(rfi_status), .slm_status(slm_status), .ais_force(ais_force),
    .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 rei_pulse", rei_pulse, m_rei);
    chk("R3 rfi_status", rfi_status, m_rfi);
    chk("R5/R6/R7/R10 slm_status", slm_status, m_slm);
    chk("R8 ais_force", ais_force, m_slm);
    chk("R4/R9 irq", irq, m_irq);
    chk("R11 v5_ready", v5_ready, 1);
  endtask

  // One clock: drive at negedge, update model, compare at next negedge.
  task automatic step(input bit vld, input logic [7:0] b, input bit [2:0] clr);
    bit [2:0] set_v = 0;
    bit       rei_n = 0;
    bit       bad;
    v5_byte  = b;
    v5_valid = vld;
    irq_clr  = clr;
    if (vld) begin
      rei_n = b[5];
      set_v[0] = b[5];
      if (b[4] != m_rfi) set_v[1] = 1;
      m_rfi = b[4];
      bad = (b[3:1] > 3'd2);
      if (bad != m_slm) begin
        m_run++;
        if (m_run == 5) begin
          m_slm = bad;
          m_run = 0;
          set_v[2] = 1;
        end
      end else begin
        m_run = 0;
      end
    end
    m_rei = rei_n;
    m_irq = (m_irq & ~clr) | set_v;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] mk(input bit rei, input bit rfi, input int lbl);
    logic [7:0] b = 8'h00;
    b[5]   = rei;
    b[4]   = rfi;
    b[3:1] = lbl[2:0];
    return b;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 reset outputs", {rei_pulse, rfi_status, slm_status, ais_force, irq}, 0);
    compare_all();

    // R2/R4: REI events, with idle gaps
    step(1, mk(1, 0, 1), 0);
    step(0, 8'hFF, 0);
    step(1, mk(0, 0, 0), 0);
    step(1, mk(1, 0, 2), 0);
    // R9: clear REI interrupt, then collision with set
    step(0, 8'h00, 3'b001);
    step(1, mk(1, 0, 0), 3'b001);
    step(0, 8'h00, 3'b001);
    // R3/R4: RFI toggles, R10 ignored while idle
    step(1, mk(0, 1, 1), 0);
    step(0, mk(0, 0, 7), 0);
    step(1, mk(0, 1, 1), 0);
    step(1, mk(0, 0, 1), 3'b010);
    step(0, 8'h00, 3'b111);

    // R7: four bad then good, with idle gaps inside run (R10)
    for (int i = 0; i < 4; i++) begin
      step(1, mk(0, 0, 3 + i), 0);
      step(0, mk(0, 0, 7), 0);
    end
    step(1, mk(0, 0, 0), 0);
    chk("R7 short bad run ignored", slm_status, 0);

    // R5: five consecutive bad labels
    for (int i = 0; i < 5; i++) step(1, mk(0, 0, 7 - i), 0);
    chk("R5 slm set after five bad", slm_status, 1);
    chk("R8 ais asserted", ais_force, 1);
    step(0, 8'h00, 3'b100);

    // R7 exit direction: four good then bad
    for (int i = 0; i < 4; i++) step(1, mk(0, 0, i % 3), 0);
    step(1, mk(0, 0, 5), 0);
    chk("R7 short good run ignored", slm_status, 1);

    // R6: five consecutive good labels, SLM irq collides with clear (R9)
    for (int i = 0; i < 4; i++) step(1, mk(0, 0, 2), 0);
    step(1, mk(0, 0, 1), 3'b100);
    chk("R6 slm cleared after five good", slm_status, 0);
    chk("R9 set beats clear", irq[2], 1);

    // mixed traffic
    for (int i = 0; i < 40; i++)
      step((i % 3) != 2, mk(i[0], i[2], (i * 5) % 8), (i % 7 == 0) ? 3'b111 : 3'b000);

    // reset again, R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_rei = 0; m_rfi = 0; m_slm = 0; m_irq = 0; m_run = 0;
    compare_all();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule